// File: doc/BRIEF.md
# Serial-Configured Clock Fan-Out Gate

This block is a write-only two-wire serial slave. It takes one fixed-format block write and loads seven configuration bytes into internal registers. The register bits and an output-enable pin together decide which of ten copies of an input clock are driven. A bus master sends the device address, then a command byte and a count byte that are both ignored, then the seven data bytes. The slave acknowledges each byte of a transaction addressed to it. A transaction with any other address leaves every register as it was.

The serial lines are sampled on the system clock through a two-flop synchroniser. A START or STOP condition is detected when SDA changes while SCL is high. The acknowledge drives SDA low through an open-drain pull output. The clock outputs are combinational gates on `clk_in`. Each output has a drive-enable flag that a pad uses to turn its driver off; a disabled output is held low with its flag low.

The receiver is a state machine with five states:
- `ST_IDLE`: waits for a START.
- `ST_RECV`: shifts in eight bits on SCL rising edges.
- `ST_ACK_WAIT`: waits for the SCL fall that ends the eighth bit.
- `ST_ACK`: pulls SDA low until the SCL fall that ends the ninth clock.
- `ST_IGNORE`: follows a mismatched address and holds until the next START or STOP.

The transitions are:
- START from any state goes to `ST_RECV` at the address byte.
- STOP from any state goes to `ST_IDLE`.
- `ST_RECV` goes to `ST_ACK_WAIT` when the eighth bit is in, or to `ST_IGNORE` if that byte was a wrong address.
- `ST_ACK_WAIT` goes to `ST_ACK` on an SCL fall.
- `ST_ACK` goes back to `ST_RECV` on an SCL fall.

Top module: `clkfan_cfg_top`

## Requirements
- R1: After reset all seven configuration registers hold 0xFF, so with `oe_i` high every output follows `clk_in` and every drive-enable flag is high.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. A START, including a repeated one, makes the next eight bits the address byte.
- R3: An address byte of 0xD2 (device address 0x69, write bit 0, sent MSB first) is acknowledged: `sda_pull_o` is high during the ninth SCL high phase. Every later byte of that transaction is acknowledged the same way. `sda_pull_o` changes only after an SCL fall or a START/STOP.
- R4: An address byte other than 0xD2 gets no acknowledge. No byte that follows it in the same transaction is acknowledged, and no register changes.
- R5: The second and third bytes of a matching transaction are acknowledged, and their values have no effect on any register.
- R6: The 4th to 10th bytes are written to registers 0 to 6 in that order. Each byte is committed when its eighth bit is received, so a STOP after a complete data byte keeps that byte.
- R7: Bytes after the tenth are acknowledged and discarded.
- R8: A STOP or repeated START in the middle of a byte discards the partial byte and leaves all registers unchanged.
- R9: With `oe_i` low, all `clk_out` bits are 0 and all `clk_drv_en` bits are 0, whatever the registers hold.
- R10: With `oe_i` high, output i is enabled by register 0 bit i for i = 0..7 and by register 1 bit i-8 for i = 8, 9. An enabled output equals `clk_in` and its flag is 1; a disabled one is 0 with its flag 0. Register 1 bits 2..7 and registers 2..6 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| oe_i | input | 1 | Output-enable pin; 0 disables every clock output |
| clk_in | input | 1 | Clock to be fanned out |
| clk_out | output | 10 | Gated copies of `clk_in` |
| clk_drv_en | output | 10 | Per-output pad drive enable |

## Verification
The bench sweeps every output, clearing one enable bit at a time. A swapped bit mapping or a byte landing one register off shows up as the wrong output going dark. It sends several wrong addresses, including the device address with the read bit set, followed by zero data. A design that matched only the upper bits, or that acknowledged anyway, would acknowledge those bytes or turn outputs off. It aborts transactions with STOP and repeated START both mid-byte and right after a complete data byte. A design that committed partial bytes, or that buffered bytes until STOP, would show the wrong enables. Finally it sends extra bytes after the tenth; a counter that wrapped would overwrite register 0.

// File: rtl/clkfan_cfg_pkg.sv
package clkfan_cfg_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK_WAIT,
        ST_ACK,
        ST_IGNORE
    } ser_state_t;

endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_s;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
            scl_q     <= scl_s;
            sda_q     <= sda_s;
        end
    end

    assign scl_s     = scl_chain[STAGES-1];
    assign sda_s     = sda_chain[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

    // R2
    cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det) && !(start_det && scl_fall));

endmodule

// File: rtl/cfg_serial_fsm.sv
module cfg_serial_fsm
    import clkfan_cfg_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR   = 7'h69,
    parameter int unsigned SKIP_BYTES = 2,
    parameter int unsigned NUM_REGS   = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_s,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic start_det,
    input  logic stop_det,
    output logic wr_en,
    output logic [$clog2(NUM_REGS)-1:0] wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic sda_pull
);

    localparam int unsigned FIRST_DATA = 1 + SKIP_BYTES;
    localparam int unsigned LAST_DATA  = FIRST_DATA + NUM_REGS - 1;
    localparam int unsigned OVF_IDX    = LAST_DATA + 1;
    localparam int unsigned IDX_W      = $clog2(OVF_IDX + 1);
    localparam int unsigned REG_IDX_W  = $clog2(NUM_REGS);
    localparam logic [BYTE_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};

    ser_state_t          state, state_nx;
    logic [2:0]          bit_cnt;
    logic [IDX_W-1:0]    byte_idx;
    logic [BYTE_W-2:0]   shreg;
    logic [BYTE_W-1:0]   rx_byte;
    logic                last_bit;
    logic                addr_bad;

    assign rx_byte  = {shreg, sda_s};
    assign last_bit = (state == ST_RECV) && scl_rise && (bit_cnt == 3'd7);
    assign addr_bad = (byte_idx == '0) && (rx_byte != ADDR_BYTE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     state_nx = ST_IDLE;
            ST_RECV:     if (last_bit) state_nx = addr_bad ? ST_IGNORE : ST_ACK_WAIT;
            ST_ACK_WAIT: if (scl_fall) state_nx = ST_ACK;
            ST_ACK:      if (scl_fall) state_nx = ST_RECV;
            ST_IGNORE:   state_nx = ST_IGNORE;
            default:     state_nx = ST_IDLE;
        endcase
        if (stop_det)       state_nx = ST_IDLE;
        else if (start_det) state_nx = ST_RECV;
    end

    // bit and byte counters, shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            byte_idx <= '0;
            shreg    <= '0;
        end else if (start_det || stop_det) begin
            bit_cnt  <= '0;
            byte_idx <= '0;
        end else begin
            if (state == ST_RECV && scl_rise) begin
                shreg   <= rx_byte[BYTE_W-2:0];
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (state == ST_ACK && scl_fall && byte_idx != IDX_W'(OVF_IDX))
                byte_idx <= byte_idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        sda_pull = (state == ST_ACK);
        wr_en    = last_bit && (byte_idx >= IDX_W'(FIRST_DATA))
                            && (byte_idx <= IDX_W'(LAST_DATA));
        wr_idx   = REG_IDX_W'(byte_idx - IDX_W'(FIRST_DATA));
        wr_data  = rx_byte;
    end

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == ST_IDLE);

    // R2
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_RECV && byte_idx == '0 && bit_cnt == 3'd0));

    // R3
    ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> $past(scl_fall || start_det || stop_det));

    // R7
    idx_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_idx <= IDX_W'(OVF_IDX));

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import clkfan_cfg_pkg::*;
#(
    parameter int unsigned NUM_REGS = 7,
    parameter int unsigned NUM_OUT  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [NUM_OUT-1:0] out_en
);

    localparam int unsigned FLAT_W = NUM_REGS * BYTE_W;

    logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
    logic [FLAT_W-1:0]               flat;

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[r] <= '1;
                else if (wr_en && wr_idx == ($clog2(NUM_REGS))'(r))
                    regs[r] <= wr_data;
            end
        end
    endgenerate

    assign flat   = regs;
    assign out_en = flat[NUM_OUT-1:0];

    // R6
    hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

endmodule

// File: rtl/cfg_clk_gate.sv
module cfg_clk_gate #(
    parameter int unsigned NUM_OUT = 10
) (
    input  logic               clk_in,
    input  logic               oe_i,
    input  logic [NUM_OUT-1:0] out_en,
    output logic [NUM_OUT-1:0] clk_out,
    output logic [NUM_OUT-1:0] drv_en
);

    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
            assign drv_en[i]  = oe_i & out_en[i];
            assign clk_out[i] = clk_in & drv_en[i];
        end
    endgenerate

endmodule

// File: rtl/clkfan_cfg_top.sv
module clkfan_cfg_top
    import clkfan_cfg_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR   = 7'h69,
    parameter int unsigned SKIP_BYTES = 2,
    parameter int unsigned NUM_REGS   = 7,
    parameter int unsigned NUM_OUT    = 10,
    parameter int unsigned SYNC_STG   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic               oe_i,
    input  logic               clk_in,
    output logic [NUM_OUT-1:0] clk_out,
    output logic [NUM_OUT-1:0] clk_drv_en
);

    localparam int unsigned REG_IDX_W = $clog2(NUM_REGS);

    logic                 sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic                 wr_en;
    logic [REG_IDX_W-1:0] wr_idx;
    logic [BYTE_W-1:0]    wr_data;
    logic [NUM_OUT-1:0]   out_en;

    cfg_sync_edge #(.STAGES(SYNC_STG)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cfg_serial_fsm #(.DEV_ADDR(DEV_ADDR), .SKIP_BYTES(SKIP_BYTES), .NUM_REGS(NUM_REGS)) fsm_i (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_pull(sda_pull_o)
    );

    cfg_regfile #(.NUM_REGS(NUM_REGS), .NUM_OUT(NUM_OUT)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .out_en(out_en)
    );

    cfg_clk_gate #(.NUM_OUT(NUM_OUT)) gate_i (
        .clk_in(clk_in), .oe_i(oe_i), .out_en(out_en),
        .clk_out(clk_out), .drv_en(clk_drv_en)
    );

    // R9
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_i |-> (clk_drv_en == '0 && clk_out == '0));

    // R4
    ack_vs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !sda_pull_o);

endmodule

// File: tb/clkfan_cfg_top_tb_top.sv
module clkfan_cfg_top_tb_top;

    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       oe = 1'b1;
    logic       cin = 1'b0;
    logic       sda_pull;
    logic       sda_line;
    logic [9:0] cout;
    logic [9:0] cdrv;

    int total = 0;
    int bad = 0;
    logic [7:0] r0 = 8'hFF;
    logic [7:0] r1 = 8'hFF;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    clkfan_cfg_top dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .oe_i(oe), .clk_in(cin),
        .clk_out(cout), .clk_drv_en(cdrv)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        logic [9:0] m;
        m = oe ? {r1[1:0], r0} : 10'h000;
        cin = 1'b1; wt(1);
        check(cout == m && cdrv == m, req, "outputs with clk_in high", int'({cout, cdrv}), int'({m, m}));
        cin = 1'b0; wt(1);
        check(cout == 10'h000 && cdrv == m, req, "outputs with clk_in low", int'({cout, cdrv}), int'({10'h000, m}));
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H);
        m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H / 2);
        acked = (sda_line == 1'b0);
        wt(H / 2); m_scl = 1'b0; wt(2);
    endtask

    // sends n bytes of seq after a START, checks each acknowledge
    task automatic send_seq(input logic [7:0] seq [12], input int n,
                            input logic exp_ack, input string req);
        logic a;
        for (int k = 0; k < n; k++) begin
            send_byte(seq[k], a);
            check(a == exp_ack, req, $sformatf("ack of byte %0d", k), int'(a), int'(exp_ack));
        end
    endtask

    task automatic full_write(input logic [7:0] cmd, input logic [7:0] cnt,
                              input logic [7:0] d0, input logic [7:0] d1, input string req);
        logic [7:0] s [12];
        s = '{8'hD2, cmd, cnt, d0, d1, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 8'h00};
        bus_start();
        send_seq(s, 10, 1'b1, req);
        bus_stop();
        r0 = d0; r1 = d1;
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] s [12];
        logic a;
        wt(4); rst_n = 1'b1; wt(4);

        // R1 reset state
        check(sda_pull == 1'b0, "R1", "no pull after reset", int'(sda_pull), 0);
        check_outs("R1");

        // R9 OE low overrides everything
        oe = 1'b0; wt(1); check_outs("R9"); oe = 1'b1; wt(1);

        // R3 R5 R6 full write, ignored bytes carry nonzero junk
        full_write(8'hA5, 8'h07, 8'h5A, 8'h01, "R3 R5 R6");
        check_outs("R6 R10");

        // R10 sweep: one enable cleared at a time, unused bits in reg1 zero
        for (int i = 0; i < 10; i++) begin
            logic [9:0] m;
            m = ~(10'h001 << i);
            full_write(8'h00, 8'hFF, m[7:0], {6'h00, m[9:8]}, "R10");
            check_outs("R10");
            oe = 1'b0; wt(1); check_outs("R9"); oe = 1'b1; wt(1);
        end

        // R4 wrong addresses: no ack, no change
        full_write(8'h3C, 8'hC3, 8'hF0, 8'h02, "R5");
        begin
            logic [7:0] bad_addr [4];
            bad_addr = '{8'hD3, 8'hD0, 8'h52, 8'hFF};
            for (int j = 0; j < 4; j++) begin
                s = '{bad_addr[j], 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
                bus_start();
                send_seq(s, 10, 1'b0, "R4");
                bus_stop();
                check_outs("R4");
            end
        end

        // R7 extra bytes after the tenth are acked and dropped
        s = '{8'hD2, 8'h00, 8'h00, 8'hC3, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        bus_start();
        send_seq(s, 12, 1'b1, "R7");
        bus_stop();
        r0 = 8'hC3; r1 = 8'h02;
        check_outs("R7");

        // R6 commit on eighth bit: STOP right after data byte 0
        s = '{8'hD2, 8'h00, 8'h00, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        bus_start();
        send_seq(s, 4, 1'b1, "R6");
        bus_stop();
        r0 = 8'h0F;
        check_outs("R6");

        // R8 STOP mid byte: partial data byte 0 discarded
        bus_start();
        send_seq(s, 3, 1'b1, "R8");
        for (int b = 0; b < 4; b++) send_bit(1'b0);
        bus_stop();
        check_outs("R8");

        // R2 R8 repeated START mid byte, then a fresh full transaction
        bus_start();
        send_seq(s, 3, 1'b1, "R8");
        for (int b = 0; b < 5; b++) send_bit(1'b0);
        s = '{8'hD2, 8'h77, 8'h88, 8'hE7, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        bus_start();
        send_seq(s, 5, 1'b1, "R2");
        bus_stop();
        r0 = 8'hE7; r1 = 8'h01;
        check_outs("R2");

        // R2 repeated START after wrong address recovers
        bus_start();
        send_byte(8'hA2, a);
        check(a == 1'b0, "R4", "wrong address ack", int'(a), 0);
        s = '{8'hD2, 8'h00, 8'h00, 8'hFF, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        bus_start();
        send_seq(s, 10, 1'b1, "R2");
        bus_stop();
        r0 = 8'hFF; r1 = 8'h03;
        check_outs("R2");
        check(sda_pull == 1'b0, "R3", "pull released at idle", int'(sda_pull), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule